// File: doc/BRIEF.md
# Multithread Fetch Priority Selector

This block sits at the front of a simultaneous-multithreading fetch stage and decides each cycle which hardware thread may fetch. It keeps live per-thread tallies, driven by one-cycle event pulses, of three things: instructions that are in the decode, rename and issue-queue stages; branch instructions in those same stages; and data-cache misses still outstanding. A policy input selects the heuristic. The policies are plain rotation, fewest in-flight branches, fewest outstanding misses, fewest in-flight instructions, or queue position. The queue-position policy uses no tallies. It favours the thread whose oldest queue entry is farthest from the head of the integer or floating-point issue queue, because a thread near the head is the one most likely to clog the queue.

The grant leaves the block as a valid/ready pair. `grant_valid` and `grant_id` are combinational from the current tallies, the eligibility mask and the rotation pointer. A grant counts as taken only in a cycle where `grant_valid` and `grant_ready` are both high. While `grant_ready` is low the rotation pointer holds, so the offered grant stays the same as long as the other inputs do not change. The event-pulse, policy and eligibility pins are plain control inputs with no handshake.

Top module: `smt_fetch_picker`

## Requirements
- R1: After reset every tally is zero and the rotation pointer points at the last thread, so thread 0 is offered first when every thread is eligible.
- R2: With policy code 0 (rotation), each accepted grant moves the offer to the next eligible thread in ascending order, wrapping from the highest ID to ID 0.
- R3: With policy code 1, the eligible thread with the fewest in-flight branches is granted. The branch tally rises on `br_enter` and falls on `br_leave`.
- R4: With policy code 2, the eligible thread with the fewest outstanding data-cache misses is granted. The miss tally rises on `miss_start` and falls on `miss_done`.
- R5: With policy code 3, the eligible thread with the fewest in-flight instructions is granted. The instruction tally rises on `ins_enter` and falls on `ins_leave`.
- R6: With policy code 4, the eligible thread with the largest `oldest_pos` field is granted. Thread t's field is bits [t*QPW +: QPW], and a larger value means farther from the queue head. The tallies have no effect in this mode.
- R7: When several eligible threads share the best value, the first of them in rotation order after the last accepted grant wins.
- R8: A tally that is at its maximum of 2^CW-1 stays there when it gets an increment without a decrement.
- R9: A tally that is at zero stays at zero when it gets a decrement without an increment.
- R10: An increment and a decrement of the same tally in the same cycle leave it unchanged.
- R11: A thread whose `eligible` bit is 0 is never granted. When no thread is eligible, `grant_valid` is 0.
- R12: In a cycle with `grant_ready` low, the rotation pointer does not move, so the next cycle offers the same grant for the same inputs.
- R13: Policy codes 5 to 7 behave as rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 3 | Priority heuristic code (0 rotation, 1 branches, 2 misses, 3 instructions, 4 queue position) |
| eligible | input | NTHR | Per-thread permission to be granted |
| ins_enter | input | NTHR | Per-thread pulse: an instruction entered the tracked stages |
| ins_leave | input | NTHR | Per-thread pulse: an instruction left the tracked stages |
| br_enter | input | NTHR | Per-thread pulse: a branch entered the tracked stages |
| br_leave | input | NTHR | Per-thread pulse: a branch left the tracked stages |
| miss_start | input | NTHR | Per-thread pulse: a data-cache miss began |
| miss_done | input | NTHR | Per-thread pulse: a data-cache miss completed |
| oldest_pos | input | NTHR*QPW | Per-thread distance of the oldest queue entry from the head |
| grant_ready | input | 1 | Fetch stage accepts the offered grant |
| grant_valid | output | 1 | A grant is offered |
| grant_id | output | $clog2(NTHR) | ID of the granted thread |

## Verification
The bench builds the block with four threads, 3-bit tallies and 4-bit queue positions. With 3-bit tallies, saturation at 7 takes only a few pulses, and a wrap past the maximum would show up as a small count that changes the grant. Four threads give room for three-way ties, sparse eligibility masks, and wrap-around of the rotation pointer within a short run.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  typedef enum logic [2:0] {
    POL_ROTATE = 3'd0,
    POL_BRANCH = 3'd1,
    POL_MISS   = 3'd2,
    POL_ICOUNT = 3'd3,
    POL_QPOS   = 3'd4
  } fetch_policy_e;
endpackage

// File: rtl/smt_sat_counter.sv
module smt_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (up && !down && count != TOP) begin
      count <= count + 1'b1;
    end else if (down && !up && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && up && !down) |=> count == TOP);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && down && !up) |=> count == '0);
  assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up && down) |=> $stable(count));
endmodule

// File: rtl/smt_prio_select.sv
module smt_prio_select #(
  parameter int N  = 4,
  parameter int KW = 4,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  eligible,
  input  logic [N*KW-1:0] keys,
  input  logic [TW-1:0] last_id,
  output logic          grant_valid,
  output logic [TW-1:0] grant_id
);
  logic [KW-1:0] best;

  always_comb begin
    grant_valid = 1'b0;
    grant_id    = '0;
    best        = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(last_id) + 1 + k) % N;
      if (eligible[idx] && (!grant_valid || keys[idx*KW +: KW] < best)) begin
        grant_valid = 1'b1;
        grant_id    = TW'(idx);
        best        = keys[idx*KW +: KW];
      end
    end
  end

  assert_grant_eligible_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> eligible[grant_id]);
  assert_idle_when_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == '0) |-> !grant_valid);
endmodule

// File: rtl/smt_fetch_picker.sv
module smt_fetch_picker
  import smt_fetch_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int CW   = 4,
  parameter int QPW  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                policy_sel,
  input  logic [NTHR-1:0]           eligible,
  input  logic [NTHR-1:0]           ins_enter,
  input  logic [NTHR-1:0]           ins_leave,
  input  logic [NTHR-1:0]           br_enter,
  input  logic [NTHR-1:0]           br_leave,
  input  logic [NTHR-1:0]           miss_start,
  input  logic [NTHR-1:0]           miss_done,
  input  logic [NTHR*QPW-1:0]       oldest_pos,
  input  logic                      grant_ready,
  output logic                      grant_valid,
  output logic [$clog2(NTHR)-1:0]   grant_id
);
  localparam int TW = $clog2(NTHR);
  localparam int KW = (CW > QPW) ? CW : QPW;
  localparam logic [QPW-1:0] QTOP = {QPW{1'b1}};

  logic [CW-1:0]      ins_cnt  [NTHR];
  logic [CW-1:0]      br_cnt   [NTHR];
  logic [CW-1:0]      miss_cnt [NTHR];
  logic [NTHR*KW-1:0] keys;
  logic [TW-1:0]      last_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    smt_sat_counter #(.W(CW)) i_ins (
      .clk(clk), .rst_n(rst_n), .up(ins_enter[t]), .down(ins_leave[t]), .count(ins_cnt[t]));
    smt_sat_counter #(.W(CW)) i_br (
      .clk(clk), .rst_n(rst_n), .up(br_enter[t]), .down(br_leave[t]), .count(br_cnt[t]));
    smt_sat_counter #(.W(CW)) i_miss (
      .clk(clk), .rst_n(rst_n), .up(miss_start[t]), .down(miss_done[t]), .count(miss_cnt[t]));

    always_comb begin
      case (policy_sel)
        POL_BRANCH: keys[t*KW +: KW] = KW'(br_cnt[t]);
        POL_MISS:   keys[t*KW +: KW] = KW'(miss_cnt[t]);
        POL_ICOUNT: keys[t*KW +: KW] = KW'(ins_cnt[t]);
        POL_QPOS:   keys[t*KW +: KW] = KW'(QTOP - oldest_pos[t*QPW +: QPW]);
        default:    keys[t*KW +: KW] = '0;
      endcase
    end
  end

  smt_prio_select #(.N(NTHR), .KW(KW), .TW(TW)) i_sel (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .keys(keys),
    .last_id(last_q), .grant_valid(grant_valid), .grant_id(grant_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= TW'(NTHR - 1);
    end else if (grant_valid && grant_ready) begin
      last_q <= grant_id;
    end
  end

  assert_hold_pointer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && grant_ready) |=> $stable(last_q));
  assert_take_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=> last_q == $past(grant_id));
endmodule

// File: tb/test_smt_fetch_picker.sv
`timescale 1ns/100ps
module test_smt_fetch_picker;
  localparam int N = 4, CW = 3, QPW = 4, TW = 2;
  localparam int CMAX = 7, QMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] pol = '0;
  logic [N-1:0] elig = '1, ie = '0, il = '0, be = '0, bl = '0, ms = '0, md = '0;
  logic [N*QPW-1:0] opos = '0;
  logic rdy = 1'b0;
  logic gv;
  logic [TW-1:0] gid;

  int checks = 0, bad = 0;
  int ci[N], cb[N], cm[N];
  int last = N - 1;
  bit finished = 0;

  typedef struct { bit v; int id; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  smt_fetch_picker #(.NTHR(N), .CW(CW), .QPW(QPW)) i_smt_fetch_picker (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .eligible(elig),
    .ins_enter(ie), .ins_leave(il), .br_enter(be), .br_leave(bl),
    .miss_start(ms), .miss_done(md), .oldest_pos(opos),
    .grant_ready(rdy), .grant_valid(gv), .grant_id(gid));

  function automatic int key_of(int t);
    case (pol)
      3'd1: return cb[t];
      3'd2: return cm[t];
      3'd3: return ci[t];
      3'd4: return QMAX - int'(opos[t*QPW +: QPW]);
      default: return 0;
    endcase
  endfunction

  function automatic int upd(int c, bit up, bit dn);
    if (up && !dn && c < CMAX) return c + 1;
    if (dn && !up && c > 0) return c - 1;
    return c;
  endfunction

  task automatic step(input string tag, input logic [2:0] p, input logic [N-1:0] e,
                      input logic [N-1:0] i_e, input logic [N-1:0] i_l,
                      input logic [N-1:0] b_e, input logic [N-1:0] b_l,
                      input logic [N-1:0] m_s, input logic [N-1:0] m_d,
                      input logic [N*QPW-1:0] op, input logic r);
    exp_t x;
    int best;
    @(negedge clk); #0.5;
    pol = p; elig = e; ie = i_e; il = i_l; be = b_e; bl = b_l;
    ms = m_s; md = m_d; opos = op; rdy = r;
    x.v = 0; x.id = 0; x.tag = tag; best = 0;
    for (int k = 0; k < N; k++) begin
      int t;
      t = (last + 1 + k) % N;
      if (e[t] && (!x.v || key_of(t) < best)) begin
        x.v = 1; x.id = t; best = key_of(t);
      end
    end
    q.push_back(x);
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      ci[t] = upd(ci[t], i_e[t], i_l[t]);
      cb[t] = upd(cb[t], b_e[t], b_l[t]);
      cm[t] = upd(cm[t], m_s[t], m_d[t]);
    end
    if (x.v && r) last = x.id;
  endtask

  // look: sample grant only, no events, pointer held
  task automatic look(input string tag, input logic [2:0] p, input logic [N-1:0] e,
                      input logic [N*QPW-1:0] op);
    step(tag, p, e, '0, '0, '0, '0, '0, '0, op, 1'b0);
  endtask

  initial begin : monitor
    forever begin
      exp_t x;
      wait (q.size() > 0);
      #0.5;
      x = q.pop_front();
      checks++;
      if (gv !== x.v || (x.v && gid !== TW'(x.id))) begin
        bad++;
        $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                 x.tag, gv, gid, x.v, x.id);
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int t = 0; t < N; t++) begin ci[t] = 0; cb[t] = 0; cm[t] = 0; end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R1 reset state: thread 0 first
    look("R1 reset offer", 3'd0, 4'b1111, '0);
    look("R12 held while not ready", 3'd0, 4'b1111, '0);
    // R2 rotation
    for (int k = 0; k < 6; k++)
      step("R2 rotate", 3'd0, 4'b1111, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    // R11 sparse eligibility and none eligible
    for (int k = 0; k < 3; k++)
      step("R11 skip ineligible", 3'd0, 4'b1010, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    look("R11 none eligible", 3'd0, 4'b0000, '0);
    // R13 unused codes rotate
    for (int k = 0; k < 3; k++)
      step("R13 code 6 rotates", 3'd6, 4'b1111, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    // build tallies: ins 0:3 1:2 2:1 3:0 ; br 0:0 1:1 2:2 3:3 ; miss 0:2 1:0 2:2 3:1
    step("R5 build", 3'd3, 4'b1111, 4'b0111, '0, 4'b1110, '0, 4'b1101, '0, '0, 1'b0);
    step("R5 build", 3'd3, 4'b1111, 4'b0011, '0, 4'b1100, '0, 4'b0101, '0, '0, 1'b0);
    step("R5 build", 3'd3, 4'b1111, 4'b0001, '0, 4'b1000, '0, '0, '0, '0, 1'b0);
    look("R5 fewest instructions", 3'd3, 4'b1111, '0);
    look("R5 fewest among 0..2", 3'd3, 4'b0111, '0);
    look("R3 fewest branches", 3'd1, 4'b1111, '0);
    look("R3 fewest among 1..3", 3'd1, 4'b1110, '0);
    look("R4 fewest misses", 3'd2, 4'b1111, '0);
    look("R4 fewest among 0,2,3", 3'd2, 4'b1101, '0);
    // R7 ties: threads 0 and 2 both 2 misses
    step("R7 tie rotates", 3'd2, 4'b0101, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    step("R7 tie rotates", 3'd2, 4'b0101, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    step("R7 tie rotates", 3'd2, 4'b0101, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    // R9 underflow: drain thread 3 miss then extra decrements
    for (int k = 0; k < 4; k++)
      step("R9 drain", 3'd2, 4'b1111, '0, '0, '0, '0, '0, 4'b1000, '0, 1'b0);
    step("R9 raise 1", 3'd2, 4'b1111, '0, '0, '0, '0, 4'b1010, '0, '0, 1'b0);
    look("R9 floor at zero", 3'd2, 4'b1010, '0);
    // R8 saturation: thread 3 instruction tally to max and beyond
    for (int k = 0; k < 10; k++)
      step("R8 fill", 3'd3, 4'b1111, 4'b1000, '0, '0, '0, '0, '0, '0, 1'b0);
    for (int k = 0; k < 6; k++)
      step("R8 fill t1", 3'd3, 4'b1111, 4'b0010, '0, '0, '0, '0, '0, '0, 1'b0);
    look("R8 saturated vs 7", 3'd3, 4'b1010, '0);
    step("R8 drop one", 3'd3, 4'b1010, '0, 4'b1000, '0, '0, '0, '0, '0, 1'b0);
    look("R8 6 beats 7", 3'd3, 4'b1010, '0);
    // R10 simultaneous inc/dec
    for (int k = 0; k < 3; k++)
      step("R10 pair", 3'd3, 4'b1111, 4'b1001, 4'b1001, '0, '0, '0, '0, '0, 1'b0);
    look("R10 unchanged", 3'd3, 4'b1001, '0);
    look("R10 unchanged alt", 3'd3, 4'b1011, '0);
    // R6 queue position, tallies ignored
    look("R6 farthest wins", 3'd4, 4'b1111, {4'd2, 4'd9, 4'd14, 4'd3});
    look("R6 farthest eligible", 3'd4, 4'b1011, {4'd2, 4'd9, 4'd14, 4'd3});
    step("R6 tie rotate", 3'd4, 4'b1111, '0, '0, '0, '0, '0, '0, {4'd7, 4'd1, 4'd7, 4'd0}, 1'b1);
    step("R6 tie rotate", 3'd4, 4'b1111, '0, '0, '0, '0, '0, '0, {4'd7, 4'd1, 4'd7, 4'd0}, 1'b1);
    // R12 hold under back-pressure
    look("R12 hold a", 3'd0, 4'b1111, '0);
    look("R12 hold b", 3'd0, 4'b1111, '0);
    step("R2 resume", 3'd0, 4'b1111, '0, '0, '0, '0, '0, '0, '0, 1'b1);
    look("R2 after resume", 3'd0, 4'b1111, '0);
    wait (q.size() == 0);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule